// File: doc/BRIEF.md
# Mode-Selectable SPI Byte Master

This block is an SPI master that exchanges one byte at a time with an attached slave over a serial clock, a data-out line and a data-in line. A small 8-bit setup register selects the clock idle level, the clock phase and the bit order. The same register holds a chip-select bit that software drives straight onto the select pin. The transfer engine never touches that pin, so software can hold the select active across several bytes.

The host starts a byte by pulsing `start` with the byte on `tx_data`. `busy` stays high while the byte is on the wire. When it finishes, `done` pulses for one cycle and `rx_data` holds the byte received. The serial clock half-period is a parameter counted in system clocks.

The engine also watches the polarity and phase bits. If either one changes while a byte is in flight, the engine drops the byte, gives no `done` pulse, and returns the clock to the new idle level.

Top module: `spi_mode_master`

## Requirements
- R1: After reset `cfg_rdata` reads 0x08. Bit 3 is chip-select (reset 1), bit 2 is LSB-first (reset 0), bit 1 is clock polarity (reset 0) and bit 0 is clock phase (reset 0). Bits 7..4 always read 0, and writes to them are ignored.
- R2: `ss_n` equals register bit 3 from the cycle after the write. A write to bit 3 during a transfer does not abort the transfer, and the engine never drives `ss_n` itself.
- R3: While idle, `sclk` rests at the polarity bit (0 gives low, 1 gives high), and it is back at that level when a byte ends.
- R4: In modes 0 (polarity 0, phase 0) and 3 (polarity 1, phase 1), `miso` is sampled on rising `sclk` edges and `mosi` changes on falling edges. With phase 0 the first bit is on `mosi` before the first edge.
- R5: In modes 1 (polarity 0, phase 1) and 2 (polarity 1, phase 0), `miso` is sampled on falling `sclk` edges and `mosi` changes on rising edges. With phase 1 the first bit is driven on the first edge.
- R6: With bit 2 at 1, both `mosi` and `miso` carry the byte LSB first. With bit 2 at 0, they carry it MSB first.
- R7: Each byte takes exactly 16 `sclk` edges, and consecutive edges are HALF_DIV system clocks apart.
- R8: `busy` rises the cycle after an accepted `start`. After the last edge, `busy` falls and `done` pulses for exactly one cycle, with `rx_data` valid in that same cycle.
- R9: A `start` pulse while `busy` is high is ignored, and the byte in progress completes unchanged.
- R10: A write that changes the polarity or phase bits during a transfer aborts it. `busy` is low and `sclk` is at the new polarity two cycles after the write, and no `done` pulse follows.
- R11: A change of bit 2 during a transfer does not affect that byte. It applies from the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_wdata | input | 8 | Setup register write data |
| cfg_rdata | output | 8 | Setup register contents |
| start | input | 1 | Begin a byte transfer |
| tx_data | input | 8 | Byte to send, taken on an accepted start |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a byte |
| rx_data | output | 8 | Byte received, valid with done |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Chip select, active low, set by software |

## Verification
The checks assume that `miso` changes only in response to `sclk`, in the slave's shift half of the period, so that it is settled when the master samples. They also assume that configuration writes are single-cycle strobes. The bench's slave model updates `miso` only on its own shift edges, and it preloads the first bit before `start` when phase is 0. Configuration writes and stray starts are issued on falling system-clock edges, one cycle wide. HALF_DIV is kept at 3 or more so the slave always has at least one system clock of setup before the next sample.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  typedef struct packed {
    logic sel_n;
    logic lsb_first;
    logic cpol;
    logic cpha;
  } spi_cfg_t;

  localparam spi_cfg_t CFG_RESET = '{sel_n: 1'b1, lsb_first: 1'b0, cpol: 1'b0, cpha: 1'b0};
endpackage

// File: rtl/spi_mm_cfg_reg.sv
module spi_mm_cfg_reg
  import spi_mm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  output spi_cfg_t   cfg,
  output logic [7:0] rdata
);
  spi_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= CFG_RESET;
    else if (we) cfg_q <= spi_cfg_t'(wdata[3:0]);
  end

  assign cfg   = cfg_q;
  assign rdata = {4'b0000, cfg_q};
endmodule

// File: rtl/spi_mm_clkgen.sv
module spi_mm_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter
  import spi_mm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  spi_cfg_t          cfg,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tick,
  input  logic              miso,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  logic              busy_q, cpol_l, cpha_l, lsb_l;
  logic [EW-1:0]     ecnt;
  logic [DATA_W-1:0] txr, rxr, rx_nxt;
  logic              abort, sample_edge, last_edge;

  function automatic logic pick(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  assign abort       = busy_q && ({cfg.cpol, cfg.cpha} != {cpol_l, cpha_l});
  assign sample_edge = (ecnt[0] == cpha_l);
  assign last_edge   = (ecnt == LAST_EDGE);
  assign rx_nxt      = lsb_l ? {miso, rxr[DATA_W-1:1]} : {rxr[DATA_W-2:0], miso};
  assign run         = busy_q && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done    <= 1'b0;
      cpol_l  <= 1'b0;
      cpha_l  <= 1'b0;
      lsb_l   <= 1'b0;
      ecnt    <= '0;
      txr     <= '0;
      rxr     <= '0;
      rx_data <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy_q) begin
        sclk <= cfg.cpol;
        if (start) begin
          busy_q <= 1'b1;
          cpol_l <= cfg.cpol;
          cpha_l <= cfg.cpha;
          lsb_l  <= cfg.lsb_first;
          ecnt   <= '0;
          rxr    <= '0;
          if (!cfg.cpha) begin
            mosi <= pick(tx_data, cfg.lsb_first);
            txr  <= advance(tx_data, cfg.lsb_first);
          end else begin
            txr  <= tx_data;
          end
        end
      end else if (abort) begin
        busy_q <= 1'b0;
        sclk   <= cfg.cpol;
      end else if (tick) begin
        sclk <= ~sclk;
        ecnt <= ecnt + 1'b1;
        if (sample_edge) begin
          rxr <= rx_nxt;
        end else if (!last_edge) begin
          mosi <= pick(txr, lsb_l);
          txr  <= advance(txr, lsb_l);
        end
        if (last_edge) begin
          busy_q  <= 1'b0;
          done    <= 1'b1;
          rx_data <= cpha_l ? rx_nxt : rxr;
        end
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
  import spi_mm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  spi_cfg_t cfg;
  logic     run, tick;

  spi_mm_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  spi_mm_clkgen #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  spi_mm_shifter #(.DATA_W(DATA_W)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .start   (start),
    .tx_data (tx_data),
    .tick    (tick),
    .miso    (miso),
    .run     (run),
    .busy    (busy),
    .done    (done),
    .rx_data (rx_data),
    .sclk    (sclk),
    .mosi    (mosi)
  );

  assign ss_n = cfg.sel_n;
endmodule

// File: rtl/spi_mm_checker.sv
module spi_mm_checker (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       sclk,
  input logic       ss_n
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[7:4] == 4'b0000);

  p_sel_write_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (ss_n == $past(cfg_wdata[3])));

  p_idle_level_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cfg_rdata[1])) |-> (sclk == cfg_rdata[1]));

  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_we && (cfg_wdata[1:0] != cfg_rdata[1:0])) |-> ##2
      (!busy && !done && (sclk == $past(cfg_wdata[1], 2))));
endmodule

bind spi_mode_master spi_mm_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .sclk      (sclk),
  .ss_n      (ss_n)
);

// File: tb/spi_mode_master_tb.sv
module spi_mode_master_tb;
  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       start = 1'b0;
  logic [7:0] tx_data = '0;
  logic       busy, done, sclk, mosi, ss_n;
  logic [7:0] rx_data;
  logic       miso = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [7:0] cfg_sh = 8'h08;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  spi_mode_master #(.DATA_W(8), .HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .start(start), .tx_data(tx_data), .busy(busy), .done(done), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected done", 1, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R8 rx_data with done", rx_data, e);
      end
    end
  end

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_sh = {4'b0000, v[3:0]};
  endtask

  function automatic logic pk(input logic [7:0] v, input bit lsb);
    return lsb ? v[0] : v[7];
  endfunction

  function automatic logic [7:0] adv(input logic [7:0] v, input bit lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  task automatic xfer(input logic [7:0] tx, input logic [7:0] srx);
    logic [7:0] s, cap;
    bit lsb, ph, pol, samp;
    int last;
    string tag;
    lsb = cfg_sh[2]; ph = cfg_sh[0]; pol = cfg_sh[1];
    tag = (pol == ph) ? "R4 mode0/3 data" : "R5 mode1/2 data";
    if (lsb) tag = {tag, " R6 lsb-first"};
    exp_q.push_back(srx);
    s = srx; cap = '0; last = 0;
    if (!ph) begin miso = pk(s, lsb); s = adv(s, lsb); end
    @(negedge clk);
    start = 1'b1; tx_data = tx;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    for (int k = 1; k <= 16; k++) begin
      @(sclk);
      if (k > 1) chk((cyc - last) == HALF, "R7 half period", cyc - last, HALF);
      last = cyc;
      samp = ((k % 2) == 1) == (ph == 1'b0);
      if (samp) cap = lsb ? {mosi, cap[7:1]} : {cap[6:0], mosi};
      else if (k != 16) begin miso = pk(s, lsb); s = adv(s, lsb); end
    end
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R8 done after 16 edges", {busy, done}, 1);
    chk(sclk == pol, "R3 sclk idle after byte", sclk, pol);
    chk(cap == tx, tag, cap, tx);
    @(negedge clk);
    chk(sclk == pol, "R7 no extra sclk edge", sclk, pol);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 8'h08, "R1 reset value", cfg_rdata, 8'h08);
    chk(ss_n == 1'b1, "R2 ss_n inactive at reset", ss_n, 1);
    chk(sclk == 1'b0 && busy == 1'b0 && done == 1'b0, "R3 idle at reset", {sclk, busy, done}, 0);

    wr_cfg(8'hF5);
    chk(cfg_rdata == 8'h05, "R1 reserved bits ignored", cfg_rdata, 8'h05);
    chk(ss_n == 1'b0, "R2 ss_n follows bit", ss_n, 0);
    repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R3 idle level cpol0", sclk, 0);

    wr_cfg(8'h00); xfer(8'hA5, 8'h3C);                 // mode 0, msb
    wr_cfg(8'h03); @(negedge clk);
    chk(sclk == 1'b1, "R3 idle level cpol1", sclk, 1);
    xfer(8'h96, 8'hE1);                                // mode 3
    wr_cfg(8'h01); xfer(8'h5A, 8'hC3);                 // mode 1
    wr_cfg(8'h02); xfer(8'h0F, 8'hF0);                 // mode 2
    wr_cfg(8'h04); xfer(8'h81, 8'h7E);                 // mode 0 lsb
    wr_cfg(8'h07); xfer(8'h35, 8'hCA);                 // mode 3 lsb
    wr_cfg(8'h06); xfer(8'hFF, 8'h00);                 // mode 2 lsb
    wr_cfg(8'h05); xfer(8'h00, 8'hFF);                 // mode 1 lsb

    // R9: start while busy ignored
    wr_cfg(8'h00);
    fork
      xfer(8'hC6, 8'h29);
      begin
        repeat (HALF * 4) @(negedge clk);
        start = 1'b1; tx_data = 8'h11;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 start while busy ignored", busy, 1);
      end
    join
    repeat (HALF * 3) @(negedge clk);
    chk(busy == 1'b0, "R9 no second transfer", busy, 0);

    // R2: ss write mid-transfer does not abort
    fork
      xfer(8'h3A, 8'h5C);
      begin
        repeat (HALF * 5) @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h08;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        chk(ss_n == 1'b1 && busy == 1'b1, "R2 ss change no abort", {ss_n, busy}, 3);
      end
    join

    // R11: bit order change mid-transfer applies next start
    wr_cfg(8'h00);
    fork
      xfer(8'h1D, 8'hB4);
      begin
        repeat (HALF * 6) @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h04;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    cfg_sh = 8'h04;
    xfer(8'h1D, 8'hB4);                                // R11 now lsb first

    // R10: abort on polarity change
    wr_cfg(8'h00);
    @(negedge clk);
    start = 1'b1; tx_data = 8'hAA;
    @(negedge clk);
    start = 1'b0;
    repeat (HALF * 3) @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'h02;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R10 abort clears busy", busy, 0);
    chk(sclk == 1'b1, "R10 sclk to new idle", sclk, 1);
    repeat (HALF * 20) @(negedge clk);
    chk(exp_q.size() == 0, "R10 no done after abort", exp_q.size(), 0);
    cfg_sh = 8'h02;
    xfer(8'h69, 8'h96);                                // recovery after abort

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule